// File: doc/BRIEF.md
# Parameter-Addressed Upgrade Register Bridge

This block puts a memory-like face on the serial register controller that governs image reconfiguration. User logic issues a one-cycle read or write request with a 3-bit parameter code. The bridge turns that request into the controller's capture, shift and update strobes. For the whole transfer it holds `busy`. A read returns the selected field right-justified on `data_out`. A write is a read-modify-write of the whole 26-bit register frame: the bridge captures the frame, shifts it out, replaces one field, forces the application-select bit to 1, shifts the frame back in and issues an update.

Writes are only honoured while the device runs the factory image (`image_app` low). When `image_app` is high, a write request is dropped and `busy` never rises. Any request or reconfiguration pulse that arrives while `busy` is high is ignored. The watchdog-restart input passes straight through at all times. The `page` output shows the page field of the last frame the bridge transferred. Before the first transfer it shows the power-up page for the selected update mode.

Top module: `ru_param_bridge`

## Requirements
- R1: A request sampled on a rising edge in idle raises `busy` from that edge. A legal read keeps `busy` high for 28 cycles (1 capture, 26 shift, 1 finish). A legal write keeps it high for 56 cycles (1 capture, 26 shift-out, 1 modify, 26 shift-in, 1 update, 1 finish).
- R2: The parameter codes and their frame fields are as follows. The frame is ordered from bit 0.
  - Code 000 selects the status field, frame bits 4:0. It is read-only.
  - Code 101 selects the image flag, frame bit 5. It is read-only.
  - Code 010 selects the watchdog timeout, frame bits 17:6.
  - Code 011 selects the watchdog enable, frame bit 18.
  - Code 100 selects the page, frame bits 25:19, of which the low `PAGE_W` bits are used.
- R3: Codes 001, 110 and 111 are illegal, and so is a write to a read-only code. Such a request keeps `busy` high for exactly one cycle and issues no serial strobe. An illegal read returns 0.
- R4: While `busy` is high, `read_param`, `write_param`, `param`, `data_in` and `reconfig` have no effect.
- R5: While `image_app` is 1, a write request is ignored: `busy` stays low and the stored register is unchanged.
- R6: Fields narrower than 12 bits take their value from the low bits of `data_in` and return it in the low bits of `data_out`, with the upper bits of `data_out` at zero.
- R7: A read returns the register that the controller captures. In the factory image this is the pending update register. In an application image it is the active control register.
- R8: A write leaves every other field of the frame unchanged and sets frame bit 5 to 1.
- R9: After reset, `busy` and `data_out` are 0. `page` is 000 when `local_mode` is 0 and 001 when it is 1.
- R10: `ser_timer_rst` follows `reset_timer` in every cycle, including while `busy` is high.
- R11: A `reconfig` pulse seen in idle gives exactly one cycle of `ser_reconfig` on the next edge.
- R12: Serial order: `ser_capture` is high for one cycle, then `ser_shift` is high for 26 cycles. Bit 0 leaves first on `ser_so` and `ser_si` enters at bit 25. During shift-out the bridge sends back what it receives. A write then shifts 26 more bits and pulses `ser_update` for one cycle.
- R13: After a legal transfer, `page` shows the low `PAGE_W` bits of the frame's page field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| read_param | input | 1 | One-cycle read request |
| write_param | input | 1 | One-cycle write request |
| param | input | 3 | Parameter code |
| data_in | input | 12 | Write data, right-justified |
| data_out | output | 12 | Read result, right-justified |
| busy | output | 1 | Transfer in progress |
| reconfig | input | 1 | Request to load the pending image |
| reset_timer | input | 1 | Watchdog restart from user logic |
| page | output | 3 | Page of the last transferred frame |
| local_mode | input | 1 | 1 selects local update mode, 0 selects remote update mode |
| image_app | input | 1 | 1 while an application image runs |
| ser_capture | output | 1 | Controller capture strobe |
| ser_shift | output | 1 | Controller shift enable |
| ser_update | output | 1 | Controller update strobe |
| ser_si | output | 1 | Serial data to the controller |
| ser_so | input | 1 | Serial data from the controller |
| ser_reconfig | output | 1 | Reconfiguration pulse to the controller |
| ser_timer_rst | output | 1 | Watchdog restart to the controller |

The state machine has seven states:
- IDLE accepts requests.
- CAPT pulses the capture strobe.
- SHOUT shifts out.
- MODIFY merges the new field.
- SHIN shifts in.
- UPDT pulses the update strobe.
- FIN loads the results.

The transitions are:
- IDLE to CAPT on a legal request.
- IDLE to FIN on an illegal request.
- CAPT to SHOUT.
- SHOUT to FIN for a read, or to MODIFY for a write, after bit 25.
- MODIFY to SHIN.
- SHIN to UPDT after bit 25.
- UPDT to FIN.
- FIN to IDLE.

## Verification
The assertions check the strobe order on every cycle: a capture is always followed by a shift, and an update only follows a shift. They also check that a request from idle raises `busy`, that an application-image write never raises it, that an illegal read ends after one busy cycle, and that a reconfiguration pulse never follows a busy cycle. Only the bench scenarios can show the data results. These are field placement and masking, preservation of the other fields across a write, the forced image bit, the factory and application read sources, and the page output in both update modes. The same applies to requests injected mid-transfer, which must leave the outcome unchanged.

// File: rtl/ru_bridge_pkg.sv
package ru_bridge_pkg;
    localparam int ST_W       = 5;
    localparam int PG_FIELD_W = 7;

    localparam logic [2:0] CODE_STATUS = 3'b000;
    localparam logic [2:0] CODE_TMO    = 3'b010;
    localparam logic [2:0] CODE_WDEN   = 3'b011;
    localparam logic [2:0] CODE_PAGE   = 3'b100;
    localparam logic [2:0] CODE_ANF    = 3'b101;

    typedef enum logic [2:0] {
        IDLE, CAPT, SHOUT, MODIFY, SHIN, UPDT, FIN
    } br_state_t;
endpackage

// File: rtl/ru_field_mux.sv
module ru_field_mux
    import ru_bridge_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int PAGE_W  = 3,
    parameter int FRAME_W = ST_W + 1 + DATA_W + 1 + PG_FIELD_W
) (
    input  logic [2:0]         code,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [FRAME_W-1:0] merged,
    output logic [PAGE_W-1:0]  frame_page,
    output logic               legal,
    output logic               writable
);
    localparam int ANF_POS = ST_W;
    localparam int TMO_LO  = ST_W + 1;
    localparam int EN_POS  = TMO_LO + DATA_W;
    localparam int PG_LO   = EN_POS + 1;

    assign frame_page = frame[PG_LO +: PAGE_W];

    always_comb begin
        rdata    = '0;
        merged   = frame;
        legal    = 1'b1;
        writable = 1'b0;
        case (code)
            CODE_STATUS: rdata[ST_W-1:0] = frame[ST_W-1:0];
            CODE_ANF:    rdata[0] = frame[ANF_POS];
            CODE_TMO: begin
                rdata = frame[TMO_LO +: DATA_W];
                merged[TMO_LO +: DATA_W] = wdata;
                writable = 1'b1;
            end
            CODE_WDEN: begin
                rdata[0] = frame[EN_POS];
                merged[EN_POS] = wdata[0];
                writable = 1'b1;
            end
            CODE_PAGE: begin
                rdata[PAGE_W-1:0] = frame[PG_LO +: PAGE_W];
                merged[PG_LO +: PG_FIELD_W] = '0;
                merged[PG_LO +: PAGE_W] = wdata[PAGE_W-1:0];
                writable = 1'b1;
            end
            default: legal = 1'b0;
        endcase
        if (writable)
            merged[ANF_POS] = 1'b1;
    end
endmodule

// File: rtl/ru_bit_counter.sv
module ru_bit_counter #(
    parameter int LEN = 26,
    localparam int CW = $clog2(LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic last
);
    logic [CW-1:0] cnt;

    assign last = en && (cnt == CW'(LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ru_param_bridge.sv
module ru_param_bridge
    import ru_bridge_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_param,
    input  logic              write_param,
    input  logic [2:0]        param,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    input  logic              reconfig,
    input  logic              reset_timer,
    output logic [PAGE_W-1:0] page,
    input  logic              local_mode,
    input  logic              image_app,
    output logic              ser_capture,
    output logic              ser_shift,
    output logic              ser_update,
    output logic              ser_si,
    input  logic              ser_so,
    output logic              ser_reconfig,
    output logic              ser_timer_rst
);
    localparam int FRAME_W = ST_W + 1 + DATA_W + 1 + PG_FIELD_W;

    br_state_t          state, state_nxt;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [2:0]         code_q;
    logic               op_rd_q, op_ill_q;
    logic [PAGE_W-1:0]  page_q;
    logic               page_seen_q;

    logic [2:0]         mux_code;
    logic [DATA_W-1:0]  mux_rdata;
    logic [FRAME_W-1:0] mux_merged;
    logic [PAGE_W-1:0]  mux_page;
    logic               mux_legal, mux_writable;
    logic               bit_last;
    logic               start_rd, start_wr, start_any, start_ok;

    assign mux_code = (state == IDLE) ? param : code_q;

    ru_field_mux #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_mux (
        .code(mux_code), .frame(frame_q), .wdata(wdata_q),
        .rdata(mux_rdata), .merged(mux_merged), .frame_page(mux_page),
        .legal(mux_legal), .writable(mux_writable)
    );

    ru_bit_counter #(.LEN(FRAME_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ser_shift), .last(bit_last)
    );

    assign start_rd  = read_param;
    assign start_wr  = !read_param && write_param && !image_app;
    assign start_any = start_rd || start_wr;
    assign start_ok  = mux_legal && (start_rd || mux_writable);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            IDLE:    if (start_any) state_nxt = start_ok ? CAPT : FIN;
            CAPT:    state_nxt = SHOUT;
            SHOUT:   if (bit_last) state_nxt = op_rd_q ? FIN : MODIFY;
            MODIFY:  state_nxt = SHIN;
            SHIN:    if (bit_last) state_nxt = UPDT;
            UPDT:    state_nxt = FIN;
            FIN:     state_nxt = IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy        = (state != IDLE);
        ser_capture = (state == CAPT);
        ser_shift   = (state == SHOUT) || (state == SHIN);
        ser_update  = (state == UPDT);
        ser_si      = (state == SHIN) ? frame_q[0] : ser_so;
    end

    assign ser_timer_rst = reset_timer;
    assign page = page_seen_q ? page_q : PAGE_W'(local_mode);

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q      <= '0;
            wdata_q      <= '0;
            code_q       <= '0;
            op_rd_q      <= 1'b0;
            op_ill_q     <= 1'b0;
            data_out     <= '0;
            page_q       <= '0;
            page_seen_q  <= 1'b0;
            ser_reconfig <= 1'b0;
        end else begin
            ser_reconfig <= reconfig && (state == IDLE);
            unique case (state)
                IDLE: if (start_any) begin
                    code_q   <= param;
                    wdata_q  <= data_in;
                    op_rd_q  <= start_rd;
                    op_ill_q <= !start_ok;
                end
                SHOUT:  frame_q <= {ser_so, frame_q[FRAME_W-1:1]};
                MODIFY: frame_q <= mux_merged;
                SHIN:   frame_q <= {frame_q[0], frame_q[FRAME_W-1:1]};
                FIN: begin
                    if (op_ill_q) begin
                        if (op_rd_q) data_out <= '0;
                    end else begin
                        page_q      <= mux_page;
                        page_seen_q <= 1'b1;
                        if (op_rd_q) data_out <= mux_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_param && !busy) |=> busy);
    // R12
    capt_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_capture |=> ser_shift);
    // R12
    update_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_update |-> $past(ser_shift));
    // R5
    app_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (write_param && !read_param && image_app && !busy) |=> !busy);
    // R3
    illegal_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_param && !busy && (param == 3'b001 || param == 3'b110 || param == 3'b111))
        |=> (busy && !ser_capture) ##1 !busy);
    // R11
    reconfig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_reconfig |-> !$past(busy));
endmodule

// File: tb/sim_ru_param_bridge.sv
module sim_ru_param_bridge;
    localparam int F = 26;

    logic clk = 0, rst_n = 0;
    logic read_param = 0, write_param = 0, reconfig = 0, reset_timer = 0, local_mode = 0;
    logic [2:0] param = 0;
    logic [11:0] data_in = 0;
    logic [11:0] data_out;
    logic [2:0] page;
    logic busy, image_app, ser_capture, ser_shift, ser_update, ser_si, ser_so;
    logic ser_reconfig, ser_timer_rst;

    int errors = 0, checks = 0, reconf_cnt = 0;

    always #2 clk = ~clk;

    // Serial controller model
    logic [F-1:0] ctrl_r, upd_r, sh_r;
    logic [4:0] stat_r;
    assign ser_so = sh_r[0];
    assign image_app = ctrl_r[5];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_r <= local_mode ? ((F'(1) << 19) | (F'(1) << 5)) : '0;
            upd_r  <= '0;
            sh_r   <= '0;
        end else begin
            if (ser_capture) sh_r <= image_app ? {ctrl_r[F-1:5], stat_r} : {upd_r[F-1:5], stat_r};
            if (ser_shift)   sh_r <= {ser_si, sh_r[F-1:1]};
            if (ser_update && !image_app) upd_r <= sh_r;
            if (ser_reconfig) begin
                ctrl_r <= upd_r;
                reconf_cnt <= reconf_cnt + 1;
            end
        end
    end

    ru_param_bridge u0 (
        .clk(clk), .rst_n(rst_n), .read_param(read_param), .write_param(write_param),
        .param(param), .data_in(data_in), .data_out(data_out), .busy(busy),
        .reconfig(reconfig), .reset_timer(reset_timer), .page(page),
        .local_mode(local_mode), .image_app(image_app), .ser_capture(ser_capture),
        .ser_shift(ser_shift), .ser_update(ser_update), .ser_si(ser_si), .ser_so(ser_so),
        .ser_reconfig(ser_reconfig), .ser_timer_rst(ser_timer_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic rd, input logic [2:0] code, input logic [11:0] d, output int nb);
        @(negedge clk);
        read_param = rd; write_param = !rd; param = code; data_in = d;
        @(negedge clk);
        read_param = 0; write_param = 0; param = 3'b111; data_in = 12'hFFF;
        nb = 0;
        while (busy && nb < 1000) begin nb++; @(negedge clk); end
    endtask

    // {tag[3:0], rd, code[2:0], data[11:0], exp[11:0], busy[7:0]}
    localparam int NV = 17;
    localparam logic [39:0] VEC [NV] = '{
        {4'd7,  1'b1, 3'b000, 12'h000, 12'h013, 8'd28}, // R7 R2 status from update reg
        {4'd1,  1'b0, 3'b010, 12'hABC, 12'h000, 8'd56}, // R1 write timing
        {4'd8,  1'b1, 3'b010, 12'h000, 12'hABC, 8'd28}, // R8 timeout stored
        {4'd8,  1'b1, 3'b101, 12'h000, 12'h001, 8'd28}, // R8 image bit forced
        {4'd6,  1'b0, 3'b011, 12'hFFE, 12'h000, 8'd56}, // R6 only LSB taken
        {4'd6,  1'b1, 3'b011, 12'h000, 12'h000, 8'd28}, // R6
        {4'd2,  1'b0, 3'b011, 12'h001, 12'h000, 8'd56}, // R2 enable field
        {4'd2,  1'b1, 3'b011, 12'h000, 12'h001, 8'd28}, // R2
        {4'd8,  1'b1, 3'b010, 12'h000, 12'hABC, 8'd28}, // R8 other field kept
        {4'd6,  1'b0, 3'b100, 12'hFF5, 12'h000, 8'd56}, // R6 page masked
        {4'd6,  1'b1, 3'b100, 12'h000, 12'h005, 8'd28}, // R6
        {4'd3,  1'b1, 3'b001, 12'h000, 12'h000, 8'd1},  // R3 illegal read
        {4'd3,  1'b0, 3'b000, 12'h000, 12'h000, 8'd1},  // R3 read-only write
        {4'd3,  1'b1, 3'b000, 12'h000, 12'h013, 8'd28}, // R3 status unchanged
        {4'd3,  1'b0, 3'b111, 12'hFFF, 12'h000, 8'd1},  // R3 illegal write
        {4'd3,  1'b1, 3'b010, 12'h000, 12'hABC, 8'd28}, // R3 no change
        {4'd3,  1'b1, 3'b110, 12'h000, 12'h000, 8'd1}   // R3 illegal read
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nb;
        stat_r = 5'h13;
        repeat (3) @(negedge clk);
        // R9 reset state, remote mode
        check("R9 busy", busy, 0);
        check("R9 data_out", data_out, 0);
        check("R9 page remote", page, 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 page after release", page, 0);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[39:36], i);
            run_op(v[35], v[34:32], v[31:20], nb);
            check({tag, " busy"}, nb, int'(v[7:0]));
            if (v[35]) check({tag, " data"}, data_out, v[19:8]);
        end
        check("R13 page output", page, 5);

        // R10 pass-through during busy
        @(negedge clk); read_param = 1; param = 3'b010;
        @(negedge clk); read_param = 0; reset_timer = 1;
        @(negedge clk);
        check("R10 timer restart while busy", ser_timer_rst, 1);
        reset_timer = 0;
        @(negedge clk);
        check("R10 timer restart low", ser_timer_rst, 0);
        while (busy) @(negedge clk);

        // R4 requests and reconfig ignored while busy
        @(negedge clk); write_param = 1; param = 3'b010; data_in = 12'h222;
        @(negedge clk); write_param = 0;
        repeat (3) @(negedge clk);
        read_param = 1; write_param = 1; param = 3'b100; data_in = 12'h003; reconfig = 1;
        @(negedge clk); read_param = 0; write_param = 0; reconfig = 0;
        while (busy) @(negedge clk);
        check("R4 no reconfig while busy", reconf_cnt, 0);
        run_op(1, 3'b010, 0, nb);
        check("R4 timeout from first write", data_out, 12'h222);
        run_op(1, 3'b100, 0, nb);
        check("R4 page untouched", data_out, 5);

        // R11 reconfig in idle
        @(negedge clk); reconfig = 1;
        @(negedge clk); reconfig = 0;
        check("R11 pulse high", ser_reconfig, 1);
        @(negedge clk);
        check("R11 pulse single", ser_reconfig, 0);
        check("R11 count", reconf_cnt, 1);
        check("R11 application running", image_app, 1);

        // R5 write in application ignored
        run_op(0, 3'b010, 12'h555, nb);
        check("R5 no busy", nb, 0);
        // R7 application read returns control register
        upd_r[17:6] = 12'h777;
        run_op(1, 3'b010, 0, nb);
        check("R7 R5 control timeout", data_out, 12'h222);

        // R9 local mode reset
        @(negedge clk); local_mode = 1; rst_n = 0;
        @(negedge clk);
        check("R9 local page", page, 1);
        check("R9 local busy", busy, 0);
        check("R9 local data_out", data_out, 0);
        rst_n = 1;
        run_op(1, 3'b100, 0, nb);
        check("R13 local page read", data_out, 1);
        check("R13 local page output", page, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule